// File: doc/BRIEF.md
# Dynamic-width bus control sequencer

This block runs one external access on a multiplexed address/data bus. The access has an address cycle, a programmable number of wait cycles before each data cycle, and one or more data cycles. The memory region behind the access may be 8, 16 or 32 bits wide. While the access runs, the block drives the control strobes that external transceivers and memories need: byte enables, a width or halted code, the data/code and write/read qualifiers, the transceiver direction and an active-low data enable.

The four byte-enable pins have different meanings for different region widths. On a 32-bit region they strobe the byte lanes. On narrower regions some of them carry the low address bits instead. The block does not split unaligned requests, does not move data and does not arbitrate the bus. It only answers a hold request, and only between accesses, by releasing its outputs.

Top module: `xbus_ctrl_seq`

## Requirements
- R1: For a 32-bit region (req_width 10, and the unused code 11, which is treated the same way) the active-low be_n equals the inverse of req_mask. Bit i of the mask enables byte lane i, and lane 3 is bits 31:24.
- R2: For a 16-bit region (req_width 01), be_n[3] is low when req_mask[1] (the high byte) is set and be_n[2] is high. be_n[1] carries address bit 1 (req_addr_lo[1]), and be_n[0] is low when req_mask[0] (the low byte) is set.
- R3: For an 8-bit region (req_width 00), be_n[3:2] are high, be_n[1] carries req_addr_lo[1] and be_n[0] carries req_addr_lo[0].
- R4: be_n is 4'b1111 outside an access. During an access it takes its value in the address cycle and keeps that value through the last data cycle.
- R5: wh_code shows the width of the running access as 00 (8-bit), 01 (16-bit) or 10 (32-bit). Between accesses it is 11 while halted is high and 00 otherwise.
- R6: wr (1 = write) and dc (1 = data, 0 = instruction fetch) are captured when the request is accepted. They are held from the address cycle through the last data cycle, and both are 0 between accesses.
- R7: dtr is high through the whole of a write access and low through a read access. It never changes between two consecutive cycles in which den_n is low.
- R8: den_n goes low in the first data cycle and stays low, including any wait cycles between beats, until the end of the last data cycle. It is high at all other times.
- R9: Exactly req_waits wait cycles come before each data cycle. A data cycle repeats while rdy is sampled low.
- R10: An access ends after req_beats+1 data cycles in which rdy is sampled high. seq_idle is high only when no access is running, and a request with req_valid high is accepted on the first clock edge at which the sequencer is idle and no hold is requested or granted.
- R11: A hold request is granted only between accesses and takes precedence over a pending request. bus_oe is low (outputs floated) from the clock edge after the request until the edge after hold_req falls.
- R12: While rst_n is low, be_n is 4'b1111, wh_code is 00, den_n is high, wr, dc and dtr are 0, seq_idle is high and bus_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_addr_lo | input | 2 | Address bits 1:0 of the access |
| req_mask | input | 4 | Active-high byte-lane mask |
| req_width | input | 2 | Region width code: 00 8-bit, 01 16-bit, 10 32-bit |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data access, 0 = instruction fetch |
| req_beats | input | BEAT_W | Number of data cycles minus one |
| req_waits | input | WAIT_W | Wait cycles before each data cycle |
| rdy | input | 1 | Data cycle completes when high |
| hold_req | input | 1 | Request to release the bus |
| halted | input | 1 | Processor halted flag |
| seq_idle | output | 1 | No access in progress |
| be_n | output | 4 | Byte enables / low address bits |
| wh_code | output | 2 | Width or halted code |
| dc | output | 1 | Data/code qualifier |
| wr | output | 1 | Write/read qualifier |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Active-low data enable |
| bus_oe | output | 1 | 0 while outputs are floated for hold |

## Verification
The assertions watch, on every cycle, that the direction output stays still while data enable is low, and that the byte enables stay constant once an access is under way. They also check that data enable and hold occur only where they are allowed, and that wait-counting and ready stalls keep the sequencer in place. Other behaviour can only be shown by the bench scenarios, which compare every output each clock against a behavioural model. These include the lane and address mapping for each region width, the exact number of wait and data cycles for different burst and stall patterns, the halted code between accesses, and the ordering between a hold and a pending or running request.

// File: rtl/xbus_pkg.sv
// Shared types for the bus control sequencer.
// Assumes: width codes are fixed by the external bus convention.
package xbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_DATA = 2'd3
    } xbus_state_e;

    localparam logic [1:0] WC_8    = 2'b00;
    localparam logic [1:0] WC_16   = 2'b01;
    localparam logic [1:0] WC_32   = 2'b10;
    localparam logic [1:0] WC_HALT = 2'b11;

    typedef struct packed {
        logic [1:0] alo;
        logic [3:0] mask;
        logic [1:0] width;
        logic       write;
        logic       data;
    } xbus_attr_t;
endpackage

// File: rtl/xbus_lane_map.sv
// Maps a latched request onto the four active-low byte-enable pins.
// Assumes: width code 11 never reaches here (normalised to 32-bit upstream).
module xbus_lane_map
    import xbus_pkg::*;
(
    input  xbus_attr_t attr,
    output logic [3:0] be_map_n
);
    // Pick lane strobes or address bits according to region width.
    always_comb begin
        unique case (attr.width)
            WC_8:    be_map_n = {2'b11, attr.alo[1], attr.alo[0]};
            WC_16:   be_map_n = {~attr.mask[1], 1'b1, attr.alo[1], ~attr.mask[0]};
            default: be_map_n = ~attr.mask;
        endcase
    end
endmodule

// File: rtl/xbus_seq_fsm.sv
// Access sequencer: address, wait and data cycles plus the hold grant.
// Assumes: request fields are stable in the cycle req_valid is accepted.
module xbus_seq_fsm
    import xbus_pkg::*;
#(
    parameter int WAIT_W = 4,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  xbus_attr_t        req_attr,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic [WAIT_W-1:0] req_waits,
    input  logic              rdy,
    input  logic              hold_req,
    output xbus_state_e       state,
    output xbus_attr_t        cur_attr,
    output logic              in_data,
    output logic              hold_grant
);
    localparam logic [WAIT_W-1:0] W_ONE = WAIT_W'(1);
    localparam logic [BEAT_W-1:0] B_ONE = BEAT_W'(1);

    logic [WAIT_W-1:0] waits_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic [BEAT_W-1:0] beats_q;
    logic              accept;

    // A request is taken only when idle and the bus is not being released.
    assign accept = (state == ST_IDLE) && req_valid && !hold_req && !hold_grant;

    // State, counters, latched attributes and hold grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_attr   <= '0;
            waits_q    <= '0;
            wcnt_q     <= '0;
            beats_q    <= '0;
            in_data    <= 1'b0;
            hold_grant <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    hold_grant <= hold_req;
                    if (accept) begin
                        state    <= ST_ADDR;
                        cur_attr <= req_attr;
                        waits_q  <= req_waits;
                        beats_q  <= req_beats;
                    end
                end
                ST_ADDR: begin
                    if (waits_q != '0) begin
                        state  <= ST_WAIT;
                        wcnt_q <= waits_q - W_ONE;
                    end else begin
                        state   <= ST_DATA;
                        in_data <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (wcnt_q == '0) begin
                        state   <= ST_DATA;
                        in_data <= 1'b1;
                    end else begin
                        wcnt_q <= wcnt_q - W_ONE;
                    end
                end
                ST_DATA: begin
                    if (rdy) begin
                        if (beats_q == '0) begin
                            state   <= ST_IDLE;
                            in_data <= 1'b0;
                        end else begin
                            beats_q <= beats_q - B_ONE;
                            if (waits_q != '0) begin
                                state  <= ST_WAIT;
                                wcnt_q <= waits_q - W_ONE;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && wcnt_q != '0) |=> state == ST_WAIT);

    // R9
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !rdy) |=> (state == ST_DATA && $stable(beats_q)));

    // R11
    grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_grant |-> state == ST_IDLE);
endmodule

// File: rtl/xbus_ctrl_seq.sv
// Top of the bus control sequencer: drives the per-access strobes from
// the sequencer state and latched request attributes.
// Assumes: unaligned requests are already split; width code 11 means 32-bit.
module xbus_ctrl_seq
    import xbus_pkg::*;
#(
    parameter int WAIT_W = 4,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_addr_lo,
    input  logic [3:0]        req_mask,
    input  logic [1:0]        req_width,
    input  logic              req_write,
    input  logic              req_data,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic [WAIT_W-1:0] req_waits,
    input  logic              rdy,
    input  logic              hold_req,
    input  logic              halted,
    output logic              seq_idle,
    output logic [3:0]        be_n,
    output logic [1:0]        wh_code,
    output logic              dc,
    output logic              wr,
    output logic              dtr,
    output logic              den_n,
    output logic              bus_oe
);
    xbus_attr_t  in_attr;
    xbus_attr_t  cur_attr;
    xbus_state_e state;
    logic        in_data;
    logic        hold_grant;
    logic [3:0]  be_map_n;
    logic        active;

    // Pack request fields, folding the unused width code onto 32-bit.
    always_comb begin
        in_attr.alo   = req_addr_lo;
        in_attr.mask  = req_mask;
        in_attr.width = (req_width == WC_HALT) ? WC_32 : req_width;
        in_attr.write = req_write;
        in_attr.data  = req_data;
    end

    xbus_seq_fsm #(.WAIT_W(WAIT_W), .BEAT_W(BEAT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_attr   (in_attr),
        .req_beats  (req_beats),
        .req_waits  (req_waits),
        .rdy        (rdy),
        .hold_req   (hold_req),
        .state      (state),
        .cur_attr   (cur_attr),
        .in_data    (in_data),
        .hold_grant (hold_grant)
    );

    xbus_lane_map u_map (
        .attr     (cur_attr),
        .be_map_n (be_map_n)
    );

    assign active = (state != ST_IDLE);

    // Strobe outputs: access values while active, idle values otherwise.
    always_comb begin
        seq_idle = !active;
        be_n     = active ? be_map_n : 4'b1111;
        wh_code  = active ? cur_attr.width : (halted ? WC_HALT : WC_8);
        dc       = active && cur_attr.data;
        wr       = active && cur_attr.write;
        dtr      = active && cur_attr.write;
        den_n    = !in_data;
        bus_oe   = !hold_grant;
    end

    // R7
    dtr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_n && $past(!den_n)) |-> $stable(dtr));

    // R4
    be_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(be_n));

    // R8
    den_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !den_n |-> !seq_idle);

    // R11
    float_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> $past(seq_idle));

    // R5
    no_halt_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_idle |-> wh_code != WC_HALT);
endmodule

// File: tb/tb_xbus_ctrl_seq.sv
// Bench: behavioural per-cycle model compared against every output each clock.
module tb_xbus_ctrl_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_addr_lo = '0;
    logic [3:0] req_mask = '0;
    logic [1:0] req_width = '0;
    logic       req_write = 1'b0;
    logic       req_data = 1'b0;
    logic [1:0] req_beats = '0;
    logic [3:0] req_waits = '0;
    logic       rdy = 1'b1;
    logic       hold_req = 1'b0;
    logic       halted = 1'b0;
    logic       seq_idle, dc, wr, dtr, den_n, bus_oe;
    logic [3:0] be_n;
    logic [1:0] wh_code;

    int errors = 0;
    int checks = 0;
    int rdy_mode = 0;
    int cyc = 0;
    bit cmp_en = 0;

    // model state
    int m_ph = 0;       // 0 idle, 1 address, 2 wait, 3 data
    int m_wleft = 0;
    int m_bleft = 0;
    int m_w = 0;
    bit m_indata = 0;
    bit m_hold = 0;
    int m_width = 0;
    int m_mask = 0;
    int m_alo = 0;
    bit m_wr = 0;
    bit m_dc = 0;

    always #5 clk = ~clk;

    xbus_ctrl_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr_lo(req_addr_lo),
        .req_mask(req_mask), .req_width(req_width), .req_write(req_write),
        .req_data(req_data), .req_beats(req_beats), .req_waits(req_waits),
        .rdy(rdy), .hold_req(hold_req), .halted(halted), .seq_idle(seq_idle),
        .be_n(be_n), .wh_code(wh_code), .dc(dc), .wr(wr), .dtr(dtr),
        .den_n(den_n), .bus_oe(bus_oe)
    );

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Behavioural model advance on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_hold = 0; m_indata = 0;
        end else if (m_ph == 0) begin
            if (req_valid && !hold_req && !m_hold) begin
                m_ph = 1;
                m_alo = int'(req_addr_lo); m_mask = int'(req_mask);
                m_width = (req_width == 2'b11) ? 2 : int'(req_width);
                m_wr = req_write; m_dc = req_data;
                m_w = int'(req_waits); m_bleft = int'(req_beats);
            end
            m_hold = hold_req;
        end else if (m_ph == 1) begin
            if (m_w > 0) begin m_ph = 2; m_wleft = m_w; end
            else begin m_ph = 3; m_indata = 1; end
        end else if (m_ph == 2) begin
            m_wleft--;
            if (m_wleft == 0) begin m_ph = 3; m_indata = 1; end
        end else begin
            if (rdy) begin
                if (m_bleft == 0) begin m_ph = 0; m_indata = 0; end
                else begin
                    m_bleft--;
                    if (m_w > 0) begin m_ph = 2; m_wleft = m_w; end
                end
            end
        end
    end

    // Expected byte enables from the latched request.
    function automatic int exp_be();
        int e;
        if (m_ph == 0) return 15;
        if (m_width == 0) return 12 + m_alo;
        if (m_width == 1) begin
            e = 4;
            if (!m_mask[1]) e += 8;
            if (m_alo[1]) e += 2;
            if (!m_mask[0]) e += 1;
            return e;
        end
        return 15 - m_mask;
    endfunction

    // Compare every output against the model before inputs move.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            string bt;
            bt = (m_ph == 0) ? "R4" : (m_width == 0) ? "R3" : (m_width == 1) ? "R2" : "R1";
            chk(bt, "be_n", int'(be_n), exp_be());
            chk("R5", "wh_code", int'(wh_code), (m_ph != 0) ? m_width : (halted ? 3 : 0));
            chk("R6", "wr", int'(wr), (m_ph != 0) ? int'(m_wr) : 0);
            chk("R6", "dc", int'(dc), (m_ph != 0) ? int'(m_dc) : 0);
            chk("R7", "dtr", int'(dtr), (m_ph != 0) ? int'(m_wr) : 0);
            chk((m_ph == 2) ? "R9" : "R8", "den_n", int'(den_n), m_indata ? 0 : 1);
            chk("R10", "seq_idle", int'(seq_idle), (m_ph == 0) ? 1 : 0);
            chk("R11", "bus_oe", int'(bus_oe), m_hold ? 0 : 1);
        end
    end

    // Ready pattern generator.
    always @(negedge clk) begin
        #1;
        rdy = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        cyc++;
    end

    task automatic issue(input [1:0] a, input [3:0] m, input [1:0] w, input bit wrt,
                         input bit dat, input [1:0] b, input [3:0] ws);
        req_addr_lo = a; req_mask = m; req_width = w; req_write = wrt;
        req_data = dat; req_beats = b; req_waits = ws; req_valid = 1'b1;
        do step(); while (m_ph == 0);
        req_valid = 1'b0;
        while (m_ph != 0) step();
        step();
    endtask

    initial begin
        repeat (3) step();
        // R12 reset values
        chk("R12", "be_n", int'(be_n), 15);
        chk("R12", "wh_code", int'(wh_code), 0);
        chk("R12", "den_n", int'(den_n), 1);
        chk("R12", "wr", int'(wr), 0);
        chk("R12", "dc", int'(dc), 0);
        chk("R12", "dtr", int'(dtr), 0);
        chk("R12", "seq_idle", int'(seq_idle), 1);
        chk("R12", "bus_oe", int'(bus_oe), 1);
        rst_n = 1'b1;
        cmp_en = 1;
        step();
        // R1 32-bit read, no waits, single beat
        issue(2'b00, 4'b0101, 2'b10, 0, 1, 2'd0, 4'd0);
        // R1 R9 R10 32-bit write burst with waits and stalls
        rdy_mode = 1;
        issue(2'b00, 4'b1111, 2'b10, 1, 1, 2'd2, 4'd2);
        // R2 16-bit write, A1 set, low byte only
        issue(2'b10, 4'b0001, 2'b01, 1, 1, 2'd1, 4'd1);
        // R2 16-bit read, high byte only, stalls without waits
        issue(2'b00, 4'b0010, 2'b01, 0, 1, 2'd3, 4'd0);
        rdy_mode = 0;
        // R3 8-bit instruction fetch at odd address
        issue(2'b11, 4'b1000, 2'b00, 0, 0, 2'd1, 4'd3);
        // R3 8-bit write at address 2
        issue(2'b10, 4'b0100, 2'b00, 1, 1, 2'd0, 4'd1);
        // R1 width code 11 treated as 32-bit
        issue(2'b00, 4'b1100, 2'b11, 1, 0, 2'd0, 4'd0);
        // R5 halted code between accesses
        halted = 1'b1;
        repeat (3) step();
        issue(2'b01, 4'b0011, 2'b01, 0, 1, 2'd0, 4'd1);
        halted = 1'b0;
        // R11 hold beats a pending request
        hold_req = 1'b1;
        step();
        req_valid = 1'b1; req_width = 2'b10; req_mask = 4'b1001; req_write = 1'b1;
        req_data = 1'b1; req_beats = 2'd0; req_waits = 4'd0;
        repeat (5) step();
        hold_req = 1'b0;
        while (m_ph == 0) step();
        req_valid = 1'b0;
        while (m_ph != 0) step();
        // R11 hold raised during an access waits for idle
        fork
            issue(2'b00, 4'b0110, 2'b10, 0, 1, 2'd2, 4'd1);
            begin repeat (3) step(); hold_req = 1'b1; end
        join
        repeat (4) step();
        hold_req = 1'b0;
        repeat (4) step();
        cmp_en = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule